// File: doc/BRIEF.md
# Hash Accelerator Control Front-End

This block is the register and data-intake side of a multi-algorithm message-digest engine. Software uses a 32-bit register bus to program a 64-bit message length in bits, a control word and the interrupt registers. Message words are then streamed through a separate write-only data port. The front end reorders the bytes of each word into message order. It counts words against the programmed length and masks the unused bytes of the final word, because the data port carries no byte-valid mask. The words go to a stand-in compression core with a fixed latency. The core pushes the digest, one 32-bit word per entry, into a queue that software drains by reading one register repeatedly.

The message-intake controller is a state machine with six states:
- S_IDLE: no message has been configured since reset.
- S_GUARD: a control write has just happened and the data port is stalled.
- S_TAKE: message words are accepted and absorbed.
- S_CRUNCH: the fixed core latency is running.
- S_EMIT: one digest word is pushed per cycle.
- S_DONE: the result is complete.

Its transitions are:
- Any state goes to S_IDLE while soft reset is held.
- Any state goes to S_GUARD on a control write.
- S_GUARD goes to S_TAKE when its counter expires, or to S_CRUNCH instead if the programmed length is zero.
- S_TAKE goes to S_CRUNCH when the last counted word is accepted.
- S_CRUNCH goes to S_EMIT when the latency counter expires.
- S_EMIT goes to S_DONE on the final digest word.

The stand-in core keeps a 32-bit accumulator. The accumulator is cleared by a control write. For each absorbed word w it is updated to rotate-left-5(acc) XOR w. Digest word j, for j counting from 0, is acc XOR j.

Top module: `hash_frontend`

## Requirements
- R1: After reset the status register (0x10) reads 0, irq is 0, dat_ready is 1, the control register (0x0C) reads 0, and the revision register (0x50) reads the REVISION parameter (default 0x00010200).
- R2: A control write at 0x0C takes the algorithm code from bits [1:0] and the byte-order code from bits [9:8]. Algorithm codes are 0 MD5, 1 SHA-1, 2 SHA-224 and 3 SHA-256. The register reads back exactly those bits, and the write starts a new message.
- R3: Each input word {d3,d2,d1,d0}, with d3 in bits [31:24], is reordered before absorption. Order 0 gives {d3,d2,d1,d0}, order 1 gives {d0,d1,d2,d3}, order 2 gives {d2,d3,d1,d0} and order 3 gives {d1,d0,d3,d2}. The byte in bits [31:24] of the result is the earliest message byte.
- R4: After a control write, dat_ready is low for the two cycles that follow, so no data word is accepted on the two clock edges after the control write edge.
- R5: The length in bits is {0x04 register, 0x08 register}. The message takes ceil(bits/32) words. In the last word only the first ceil(bits/8) mod 4 bytes after reordering are kept, where 0 means all 4, and the other bytes are zeroed. A zero length completes with no data. Words beyond the length are dropped.
- R6: The digest holds 4, 5, 7 or 8 words for algorithm codes 0, 1, 2 and 3. Word j is acc XOR j, and the words are read in order j = 0 upward.
- R7: Each read of 0x1C pops one word. A read of an empty queue returns 0 and sets status bit 2.
- R8: A data word accepted before any control write since reset is discarded and sets status bit 3.
- R9: Status bit 1 is set once, on the edge that pushes the final digest word. Status bit 0 reads 1 while the queue is not empty. Status bit 8 is the OR of bits 0 to 3.
- R10: Writing a mask to 0x18 clears the matching sticky status bits 1 to 3. If a set event and a clear hit the same bit on the same edge, the set wins.
- R11: irq is the OR of status bits 0 to 3 each ANDed with the matching bit of the enable register (0x14).
- R12: Writing 1 to bit 0 of 0x00 holds soft reset. While it is held, the queue is empty, the status reads 0, and data writes and control writes start nothing and flag nothing. Writing 0 releases it, and the block is then unconfigured as after reset.
- R13: A control write in the middle of a message abandons that message. The accumulator and the queue are cleared, and the digest reflects only the new message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data one cycle later) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, zero when no read |
| dat_valid | input | 1 | Message word offered |
| dat_word | input | 32 | Message word |
| dat_ready | output | 1 | Data port can accept this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties watch, on every cycle, several rules:
- the data port stays stalled on both cycles that follow a control write;
- the intake never absorbs more words than the programmed length allows;
- the completion pulse lasts one cycle;
- the result queue is never pushed while full;
- an empty-queue read always leaves the read error flagged;
- an enabled completion always raises irq.

Only the bench's scenarios can show the following:
- that digest values match the byte-order and last-word masking rules across random lengths, orders and algorithms;
- that a restart mid-message discards the old data;
- that soft reset returns the block to the unconfigured state.

// File: rtl/hfe_pkg.sv
`timescale 1ns/1ps
package hfe_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int MSG_LEN_W  = 64;

    typedef enum logic [1:0] {
        ALG_MD5    = 2'd0,
        ALG_SHA1   = 2'd1,
        ALG_SHA224 = 2'd2,
        ALG_SHA256 = 2'd3
    } algo_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GUARD,
        S_TAKE,
        S_CRUNCH,
        S_EMIT,
        S_DONE
    } intake_e;

    localparam logic [7:0] OFS_RESET  = 8'h00;
    localparam logic [7:0] OFS_LEN_HI = 8'h04;
    localparam logic [7:0] OFS_LEN_LO = 8'h08;
    localparam logic [7:0] OFS_CTRL   = 8'h0C;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_ENAB   = 8'h14;
    localparam logic [7:0] OFS_CLR    = 8'h18;
    localparam logic [7:0] OFS_RESQ   = 8'h1C;
    localparam logic [7:0] OFS_REV    = 8'h50;

    localparam int ST_AVAIL = 0;
    localparam int ST_NEW   = 1;
    localparam int ST_RDERR = 2;
    localparam int ST_WRERR = 3;
    localparam int ST_RAW   = 8;

    function automatic logic [3:0] digest_len(algo_e a);
        logic [3:0] n;
        unique case (a)
            ALG_MD5:    n = 4'd4;
            ALG_SHA1:   n = 4'd5;
            ALG_SHA224: n = 4'd7;
            ALG_SHA256: n = 4'd8;
        endcase
        return n;
    endfunction

    // Source lane feeding output lane 'lane' (lane 3 is the MSB byte).
    function automatic logic [1:0] src_lane(logic [1:0] order, logic [1:0] lane);
        logic [1:0] s;
        unique case (order)
            2'd0: s = lane;
            2'd1: s = 2'd3 - lane;
            2'd2: s = lane[1] ? (lane ^ 2'd1) : lane;
            2'd3: s = lane ^ 2'd2;
        endcase
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] rotl5(logic [WORD_W-1:0] v);
        return {v[WORD_W-6:0], v[WORD_W-1:WORD_W-5]};
    endfunction

endpackage

// File: rtl/hfe_lane_swap.sv
`timescale 1ns/1ps
module hfe_lane_swap
    import hfe_pkg::*;
(
    input  logic [1:0]        order,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        logic [1:0] sel;
        always_comb begin
            sel = src_lane(order, 2'(l));
            dout[8*l +: 8] = din[8*sel +: 8];
        end
    end

endmodule

// File: rtl/hfe_result_fifo.sv
`timescale 1ns/1ps
module hfe_result_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             push_ok, pop_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wptr] <= push_data;
    end

    // R6: a digest always fits; the core never pushes into a full queue
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full);

endmodule

// File: rtl/hfe_intake_fsm.sv
`timescale 1ns/1ps
module hfe_intake_fsm
    import hfe_pkg::*;
#(
    parameter int GUARD_CYC = 2,
    parameter int LATENCY   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hold,
    input  logic                 start,
    input  algo_e                algo,
    input  logic [MSG_LEN_W-1:0] msg_bits,
    input  logic                 dat_valid,
    input  logic [WORD_W-1:0]    dat_word,
    output logic                 dat_ready,
    output logic                 push,
    output logic [WORD_W-1:0]    push_word,
    output logic                 done_pulse,
    output logic                 early_write
);

    localparam int WC_W = MSG_LEN_W - 4;
    localparam int GC_W = $clog2(GUARD_CYC + 1);
    localparam int LC_W = $clog2(LATENCY + 1);

    intake_e           state, nxt;
    logic [GC_W-1:0]   gcnt;
    logic [LC_W-1:0]   lcnt;
    logic [3:0]        eidx;
    logic [WC_W-1:0]   widx;
    logic [WORD_W-1:0] acc;

    logic [MSG_LEN_W:0] bits_ext;
    logic [WC_W-1:0]    total_words;
    logic [4:0]         tail;
    logic [2:0]         keep;
    logic [WORD_W-1:0]  masked;
    logic               is_last, fire, last_emit;
    logic [3:0]         nwords;

    assign bits_ext    = {1'b0, msg_bits} + (MSG_LEN_W + 1)'(31);
    assign total_words = bits_ext[MSG_LEN_W:5];
    assign tail        = msg_bits[4:0] + 5'd7;
    assign keep        = (tail[4:3] == 2'd0) ? 3'd4 : {1'b0, tail[4:3]};
    assign is_last     = (widx == total_words - WC_W'(1));
    assign nwords      = digest_len(algo);
    assign last_emit   = (eidx == nwords - 4'd1);

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_mask
        localparam logic [2:0] RANK = 3'(WORD_BYTES - 1 - l);
        assign masked[8*l +: 8] = (RANK < keep) ? dat_word[8*l +: 8] : 8'h00;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        if (hold) begin
            nxt = S_IDLE;
        end else if (start) begin
            nxt = S_GUARD;
        end else begin
            unique case (state)
                S_IDLE:   nxt = S_IDLE;
                S_GUARD:  if (gcnt == '0) nxt = (total_words == '0) ? S_CRUNCH : S_TAKE;
                S_TAKE:   if (fire && is_last) nxt = S_CRUNCH;
                S_CRUNCH: if (lcnt == '0) nxt = S_EMIT;
                S_EMIT:   if (last_emit) nxt = S_DONE;
                S_DONE:   nxt = S_DONE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        dat_ready   = (state != S_GUARD);
        push        = (state == S_EMIT);
        push_word   = acc ^ {{(WORD_W-4){1'b0}}, eidx};
        done_pulse  = (state == S_EMIT) && last_emit && !hold && !start;
        early_write = (state == S_IDLE) && dat_valid && !hold;
    end

    assign fire = dat_valid && dat_ready;

    // Datapath counters and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gcnt <= '0;
            lcnt <= '0;
            eidx <= '0;
            widx <= '0;
            acc  <= '0;
        end else if (start) begin
            gcnt <= GC_W'(GUARD_CYC - 1);
            widx <= '0;
            acc  <= '0;
        end else begin
            if (state == S_GUARD && gcnt != '0) gcnt <= gcnt - 1'b1;
            if (state == S_TAKE && fire) begin
                acc  <= rotl5(acc) ^ (is_last ? masked : dat_word);
                widx <= widx + 1'b1;
            end
            lcnt <= (state == S_CRUNCH) ? lcnt - 1'b1 : LC_W'(LATENCY - 1);
            eidx <= (state == S_EMIT) ? eidx + 1'b1 : 4'd0;
        end
    end

    // R4: port stalled on the first cycle after a control write
    a_r4_guard_first: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !dat_ready);
    // R4: and on the second cycle
    a_r4_guard_second: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && !hold) |=> !dat_ready);
    // R5: never more words absorbed than the length allows
    a_r5_no_excess: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TAKE) |-> (widx < total_words));
    // R9: completion is a single-cycle event
    a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

endmodule

// File: rtl/hash_frontend.sv
`timescale 1ns/1ps
module hash_frontend
    import hfe_pkg::*;
#(
    parameter int          GUARD_CYC = 2,
    parameter int          LATENCY   = 4,
    parameter int          QDEPTH    = 8,
    parameter logic [31:0] REVISION  = 32'h0001_0200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dat_valid,
    input  logic [31:0] dat_word,
    output logic        dat_ready,
    output logic        irq
);

    logic        soft_rst;
    logic [31:0] len_hi, len_lo;
    algo_e       algo;
    logic [1:0]  order;
    logic [3:0]  enab;
    logic        sts_new, sts_rderr, sts_wrerr;
    logic [3:0]  sts_lo;
    logic [31:0] status, rd_mux;

    logic        start, flush, q_pop, q_empty, q_full;
    logic        push, done_pulse, early_write;
    logic [31:0] push_word, q_head, swapped;
    logic        unused_bits;

    assign unused_bits = ^{reg_wdata[31:10], reg_wdata[7:4], q_full};

    assign start = reg_wr && (reg_addr == OFS_CTRL) && !soft_rst;
    assign flush = start || soft_rst;
    assign q_pop = reg_rd && (reg_addr == OFS_RESQ);

    hfe_lane_swap u_swap (
        .order (order),
        .din   (dat_word),
        .dout  (swapped)
    );

    hfe_intake_fsm #(
        .GUARD_CYC (GUARD_CYC),
        .LATENCY   (LATENCY)
    ) u_intake (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (soft_rst),
        .start       (start),
        .algo        (algo),
        .msg_bits    ({len_hi, len_lo}),
        .dat_valid   (dat_valid),
        .dat_word    (swapped),
        .dat_ready   (dat_ready),
        .push        (push),
        .push_word   (push_word),
        .done_pulse  (done_pulse),
        .early_write (early_write)
    );

    hfe_result_fifo #(
        .WIDTH (32),
        .DEPTH (QDEPTH)
    ) u_resq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (push_word),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_rst <= 1'b0;
            len_hi   <= '0;
            len_lo   <= '0;
            algo     <= ALG_MD5;
            order    <= 2'd0;
            enab     <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_RESET:  soft_rst <= reg_wdata[0];
                OFS_LEN_HI: len_hi   <= reg_wdata;
                OFS_LEN_LO: len_lo   <= reg_wdata;
                OFS_CTRL: begin
                    algo  <= algo_e'(reg_wdata[1:0]);
                    order <= reg_wdata[9:8];
                end
                OFS_ENAB:   enab     <= reg_wdata[3:0];
                default: ;
            endcase
        end
    end

    // Sticky status bits: set beats clear
    logic clr_hit;
    assign clr_hit = reg_wr && (reg_addr == OFS_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_new   <= 1'b0;
            sts_rderr <= 1'b0;
            sts_wrerr <= 1'b0;
        end else if (soft_rst) begin
            sts_new   <= 1'b0;
            sts_rderr <= 1'b0;
            sts_wrerr <= 1'b0;
        end else begin
            if (done_pulse)                       sts_new   <= 1'b1;
            else if (clr_hit && reg_wdata[ST_NEW]) sts_new   <= 1'b0;
            if (q_pop && q_empty)                 sts_rderr <= 1'b1;
            else if (clr_hit && reg_wdata[ST_RDERR]) sts_rderr <= 1'b0;
            if (early_write)                      sts_wrerr <= 1'b1;
            else if (clr_hit && reg_wdata[ST_WRERR]) sts_wrerr <= 1'b0;
        end
    end

    assign sts_lo = {sts_wrerr, sts_rderr, sts_new, !q_empty};
    assign irq    = |(sts_lo & enab);

    always_comb begin
        status         = '0;
        status[3:0]    = sts_lo;
        status[ST_RAW] = |sts_lo;
    end

    always_comb begin
        case (reg_addr)
            OFS_RESET:  rd_mux = {31'b0, soft_rst};
            OFS_LEN_HI: rd_mux = len_hi;
            OFS_LEN_LO: rd_mux = len_lo;
            OFS_CTRL:   rd_mux = {22'b0, order, 6'b0, algo};
            OFS_STAT:   rd_mux = status;
            OFS_ENAB:   rd_mux = {28'b0, enab};
            OFS_RESQ:   rd_mux = q_empty ? 32'h0 : q_head;
            OFS_REV:    rd_mux = REVISION;
            default:    rd_mux = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= reg_rd ? rd_mux : 32'h0;
    end

    // R7: a read of an empty queue leaves the read error flagged
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop && q_empty && !soft_rst) |=> sts_rderr);
    // R11: an enabled completion raises irq
    a_r11_irq_new: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && enab[ST_NEW] && !(reg_wr && reg_addr == OFS_ENAB)) |=> irq);

endmodule

// File: tb/test_hash_frontend.sv
`timescale 1ns/1ps
module test_hash_frontend;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd, dat_valid;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata, dat_word;
    logic        dat_ready, irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [31:0] msg [0:15];

    always #4 clk = ~clk;

    hash_frontend i_hash_frontend (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dat_valid (dat_valid),
        .dat_word  (dat_word),
        .dat_ready (dat_ready),
        .irq       (irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog R1..: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        dat_valid = 1'b1; dat_word = w;
        while (!dat_ready) @(negedge clk);
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    function automatic logic [31:0] swz(input logic [1:0] ord, input logic [31:0] w);
        case (ord)
            2'd0: return w;
            2'd1: return {w[7:0], w[15:8], w[23:16], w[31:24]};
            2'd2: return {w[23:16], w[31:24], w[15:8], w[7:0]};
            default: return {w[15:8], w[7:0], w[31:24], w[23:16]};
        endcase
    endfunction

    function automatic logic [31:0] model_acc(input int nbits, input logic [1:0] ord);
        logic [31:0] a = 32'h0;
        logic [31:0] w;
        int nw = (nbits + 31) / 32;
        int keep;
        for (int i = 0; i < nw; i++) begin
            w = swz(ord, msg[i]);
            if (i == nw - 1) begin
                keep = ((nbits + 7) / 8) % 4;
                if (keep == 0) keep = 4;
                w = w & ~(32'hFFFF_FFFF >> (8 * keep));
            end
            a = {a[26:0], a[31:27]} ^ w;
        end
        return a;
    endfunction

    function automatic int dlen(input logic [1:0] alg);
        case (alg)
            2'd0: return 4;
            2'd1: return 5;
            2'd2: return 7;
            default: return 8;
        endcase
    endfunction

    task automatic wait_done(output logic [31:0] s);
        for (int k = 0; k < 300; k++) begin
            reg_read(8'h10, s);
            if (s[1]) break;
        end
    endtask

    task automatic run_msg(input logic [1:0] alg, input logic [1:0] ord, input int nbits,
                           input bit extra, input bit en_new);
        logic [31:0] s, d, acc;
        int nw = (nbits + 31) / 32;
        reg_write(8'h14, en_new ? 32'h2 : 32'h0);
        reg_write(8'h04, 32'h0);
        reg_write(8'h08, nbits);
        reg_write(8'h0C, {22'b0, ord, 6'b0, alg});
        check32("R4 stall cycle 1", {31'b0, dat_ready}, 32'd0);
        @(negedge clk);
        check32("R4 stall cycle 2", {31'b0, dat_ready}, 32'd0);
        @(negedge clk);
        check32("R4 ready after guard", {31'b0, dat_ready}, 32'd1);
        reg_read(8'h0C, d);
        check32("R2 control readback", d, {22'b0, ord, 6'b0, alg});
        for (int i = 0; i < nw; i++) push_word(msg[i]);
        wait_done(s);
        check32("R9 new+avail set", s & 32'h10F, 32'h103);
        check32("R11 irq on enabled completion", {31'b0, irq}, {31'b0, en_new});
        if (extra) push_word(32'hDEAD_BEEF);
        acc = model_acc(nbits, ord);
        for (int j = 0; j < dlen(alg); j++) begin
            reg_read(8'h1C, d);
            check32("R3 R5 R6 digest word", d, acc ^ j);
        end
        reg_read(8'h1C, d);
        check32("R7 empty read value", d, 32'h0);
        reg_read(8'h10, s);
        check32("R7 R9 status after drain", s, 32'h106);
        reg_write(8'h18, 32'hE);
        reg_read(8'h10, s);
        check32("R10 status cleared", s, 32'h0);
        check32("R11 irq low after clear", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        logic [31:0] s, d;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        dat_valid = 0; dat_word = 0;
        rst_n = 1'b0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check32("R1 irq", {31'b0, irq}, 32'd0);
        check32("R1 ready", {31'b0, dat_ready}, 32'd1);
        reg_read(8'h10, s);
        check32("R1 status", s, 32'h0);
        reg_read(8'h50, d);
        check32("R1 revision", d, 32'h0001_0200);
        reg_read(8'h0C, d);
        check32("R1 control", d, 32'h0);

        // R8 data before configuration, R11 enable, R10 clear
        push_word(32'h1122_3344);
        reg_read(8'h10, s);
        check32("R8 write error", s, 32'h108);
        reg_write(8'h14, 32'h8);
        check32("R11 irq from write error", {31'b0, irq}, 32'd1);
        reg_write(8'h18, 32'h8);
        check32("R10 irq after clear", {31'b0, irq}, 32'd0);
        reg_read(8'h10, s);
        check32("R10 status after clear", s, 32'h0);

        // Directed corner cases
        run_msg(2'd2, 2'd3, 0, 1'b0, 1'b0);                  // R5 zero length
        msg[0] = 32'hA1B2_C3D4;
        run_msg(2'd0, 2'd0, 32, 1'b1, 1'b1);                 // R5 one full word + extra
        msg[0] = 32'h0102_0304;
        run_msg(2'd3, 2'd1, 8, 1'b0, 1'b0);                  // R5 single byte
        msg[0] = 32'hCAFE_F00D; msg[1] = 32'h5566_7788;
        run_msg(2'd1, 2'd2, 33, 1'b0, 1'b1);                 // R3 order 2, partial tail

        // R13 restart mid-message
        reg_write(8'h08, 32'd160);
        reg_write(8'h0C, 32'h1);
        push_word(32'h9999_0000);
        push_word(32'h0000_9999);
        for (int i = 0; i < 3; i++) msg[i] = $urandom;
        run_msg(2'd3, 2'd0, 72, 1'b0, 1'b0);                 // R13 digest of new msg only

        // Random messages
        for (int it = 0; it < 10; it++) begin
            logic [1:0] alg, ord;
            int nb;
            alg = 2'($urandom % 4);
            ord = 2'($urandom % 4);
            nb  = $urandom_range(1, 512);
            for (int i = 0; i < 16; i++) msg[i] = $urandom;
            run_msg(alg, ord, nb, 1'($urandom % 2), 1'($urandom % 2));
        end

        // R12 soft reset
        reg_write(8'h08, 32'd64);
        reg_write(8'h0C, 32'h3);
        push_word(32'h1234_5678);
        push_word(32'h8765_4321);
        wait_done(s);
        check32("R12 precondition done", s & 32'h3, 32'h3);
        reg_write(8'h00, 32'h1);
        reg_read(8'h00, d);
        check32("R12 reset readback", d, 32'h1);
        reg_read(8'h10, s);
        check32("R12 status held clear", s, 32'h0);
        reg_read(8'h1C, d);
        check32("R12 queue flushed", d, 32'h0);
        push_word(32'h0BAD_0BAD);
        reg_write(8'h0C, 32'h1);
        reg_read(8'h10, s);
        check32("R12 no flags while held", s, 32'h0);
        reg_write(8'h00, 32'h0);
        push_word(32'h0BAD_0BAD);
        reg_read(8'h10, s);
        check32("R12 unconfigured after release", s, 32'h108);
        reg_write(8'h18, 32'hE);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule